// File: doc/BRIEF.md
# Single-Step Trace Exception Sequencer

This block raises trace exceptions so that a debugger can step a processor one instruction at a time. Each time the pipeline reports that an instruction has completed, the block looks at the trace bit of the status register. If the bit is set, it requests a trace exception and presents the frame contents for the exception logic to stack: the saved PC, which is the address of the next instruction, and the saved status register. It then holds that frame and ignores further completions until the exception logic acknowledges the request.

The stop instruction is handled separately. A completed stop never raises the ordinary trace. The block first issues a one-cycle status-register load carrying the stop's 16-bit immediate operand. If the trace bit of that newly loaded value is set, the block then raises a trace whose saved PC is the address after the stop (stop PC + 4, because of the extension word) and whose saved status register is the loaded value. Once that trace is acknowledged, or straight after the load if no trace is due, it pulses a signal that tells the low-power controller that stop has been entered. The instruction before a stop needs no special handling: it traces normally, and its saved PC, being its next PC, already points at the stop opword.

The sequencer has five states. RUN is idle and accepting completions. REQ is the cycle of the request pulse. WAIT holds the frame until acknowledge. LOAD is the cycle of the status-register load. SIGNAL is the cycle of the stop-entered pulse. The transitions are as follows. RUN goes to REQ on a traced ordinary completion and to LOAD on a stop completion. REQ and WAIT go to RUN on acknowledge of an ordinary trace, and to SIGNAL on acknowledge of a post-stop trace. REQ moves to WAIT if no acknowledge arrives. LOAD goes to REQ, marked as post-stop, when the loaded trace bit is 1, and to SIGNAL when it is 0. SIGNAL always returns to RUN.

Top module: `trace_seq`

## Requirements
- R1: A synchronous reset clears all pending trace state. While `rst` is high and in the cycle after it falls, `trc_req`, `sr_load` and `stop_entered` are 0, and `trc_pc` and `trc_sr` are 0.
- R2: An ordinary completion (`ins_done`=1, `ins_stop`=0) seen in the idle state with `sr_val` bit 15 (the trace bit) set makes `trc_req` high in the next cycle. In that cycle `trc_pc` equals that completion's `ins_next_pc` and `trc_sr` equals its `sr_val`.
- R3: An ordinary completion with `sr_val` bit 15 clear raises no trace, and `trc_pc` and `trc_sr` keep their values.
- R4: `trc_req` is high for exactly one cycle per trace. `trc_pc` and `trc_sr` stay stable from the request until the acknowledge.
- R5: While a trace, load or stop sequence is in progress, further completions are ignored. They raise no request, and the frame outputs do not change.
- R6: `exc_ack` in the request cycle or any later cycle ends an ordinary trace, and a completion in the following cycle is accepted. `exc_ack` with nothing pending has no effect.
- R7: A stop completion (`ins_stop`=1) never raises the ordinary trace, whatever `sr_val` holds. In the next cycle `sr_load` is high for one cycle, with `sr_load_val` equal to `stop_imm`.
- R8: If bit 15 of `stop_imm` is 1, `trc_req` rises in the cycle after `sr_load`, with `trc_pc` = stop PC + 4 and `trc_sr` = `stop_imm`.
- R9: If bit 15 of `stop_imm` is 0, no trace follows the load, and `stop_entered` pulses for one cycle in the cycle after `sr_load`.
- R10: After a post-stop trace, `stop_entered` pulses for one cycle in the cycle after the acknowledge. The block then returns to idle.
- R11: `trc_req`, `sr_load` and `stop_entered` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_done | input | 1 | Instruction-complete strobe |
| ins_stop | input | 1 | Completed instruction is stop |
| ins_pc | input | 32 | PC of the completed instruction |
| ins_next_pc | input | 32 | PC of the instruction that follows |
| stop_imm | input | 16 | Immediate operand of a stop |
| sr_val | input | 16 | Current status register, trace bit at bit 15 |
| exc_ack | input | 1 | Trace exception taken |
| trc_req | output | 1 | One-cycle trace exception request |
| trc_pc | output | 32 | PC to save in the exception frame |
| trc_sr | output | 16 | Status register to save in the frame |
| sr_load | output | 1 | Load the status register (stop executing) |
| sr_load_val | output | 16 | Value to load into the status register |
| stop_entered | output | 1 | Stop has taken effect; low-power entry may begin |

## Verification
A wrong internal state shows at the ports within one or two cycles. A lost pending flag lets a second completion raise a request, or a second request, while a frame is still held. A stuck post-stop mark misplaces or drops the `stop_entered` pulse after an acknowledge. A bad capture gives a frame PC that is off by the stop length or taken from the wrong input. The bench models the expected outputs cycle by cycle and compares every port on every clock. Most faults therefore appear in the first cycle in which the model and the design disagree.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_REQ    = 3'd1,
        ST_WAIT   = 3'd2,
        ST_LOAD   = 3'd3,
        ST_SIGNAL = 3'd4
    } tseq_state_e;

endpackage

// File: rtl/trace_seq_fsm.sv
module trace_seq_fsm
    import trace_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ins_done,
    input  logic        ins_stop,
    input  logic        t_now,
    input  logic        t_loaded,
    input  logic        exc_ack,
    output logic        cap_norm,
    output logic        cap_stop,
    output logic        trc_req,
    output logic        sr_load,
    output logic        stop_entered
);

    tseq_state_e state_q, state_d;
    logic        post_q, post_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            post_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            post_q  <= post_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        post_d  = post_q;
        unique case (state_q)
            ST_RUN: begin
                if (ins_done && ins_stop) begin
                    state_d = ST_LOAD;
                end else if (ins_done && t_now) begin
                    state_d = ST_REQ;
                    post_d  = 1'b0;
                end
            end
            ST_REQ: begin
                if (exc_ack) state_d = post_q ? ST_SIGNAL : ST_RUN;
                else         state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (exc_ack) state_d = post_q ? ST_SIGNAL : ST_RUN;
            end
            ST_LOAD: begin
                if (t_loaded) begin
                    state_d = ST_REQ;
                    post_d  = 1'b1;
                end else begin
                    state_d = ST_SIGNAL;
                end
            end
            ST_SIGNAL: begin
                state_d = ST_RUN;
                post_d  = 1'b0;
            end
            default: begin
                state_d = ST_RUN;
                post_d  = 1'b0;
            end
        endcase
    end

    // outputs
    always_comb begin
        cap_norm     = (state_q == ST_RUN) && ins_done && !ins_stop && t_now;
        cap_stop     = (state_q == ST_RUN) && ins_done && ins_stop;
        trc_req      = (state_q == ST_REQ);
        sr_load      = (state_q == ST_LOAD);
        stop_entered = (state_q == ST_SIGNAL);
    end

endmodule

// File: rtl/trace_seq_frame.sv
module trace_seq_frame #(
    parameter int AW       = 32,
    parameter int SW       = 16,
    parameter int STOP_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_norm,
    input  logic          cap_stop,
    input  logic [AW-1:0] ins_pc,
    input  logic [AW-1:0] ins_next_pc,
    input  logic [SW-1:0] sr_val,
    input  logic [SW-1:0] stop_imm,
    output logic [AW-1:0] pc_q,
    output logic [SW-1:0] sr_q
);

    localparam logic [AW-1:0] STOP_STEP = AW'(STOP_LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            sr_q <= '0;
        end else if (cap_stop) begin
            pc_q <= ins_pc + STOP_STEP;
            sr_q <= stop_imm;
        end else if (cap_norm) begin
            pc_q <= ins_next_pc;
            sr_q <= sr_val;
        end
    end

endmodule

// File: rtl/trace_seq.sv
module trace_seq #(
    parameter int AW       = 32,
    parameter int SW       = 16,
    parameter int TBIT     = 15,
    parameter int STOP_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ins_done,
    input  logic          ins_stop,
    input  logic [AW-1:0] ins_pc,
    input  logic [AW-1:0] ins_next_pc,
    input  logic [SW-1:0] stop_imm,
    input  logic [SW-1:0] sr_val,
    input  logic          exc_ack,
    output logic          trc_req,
    output logic [AW-1:0] trc_pc,
    output logic [SW-1:0] trc_sr,
    output logic          sr_load,
    output logic [SW-1:0] sr_load_val,
    output logic          stop_entered
);

    logic          cap_norm;
    logic          cap_stop;
    logic [AW-1:0] pc_q;
    logic [SW-1:0] sr_q;

    trace_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ins_done     (ins_done),
        .ins_stop     (ins_stop),
        .t_now        (sr_val[TBIT]),
        .t_loaded     (sr_q[TBIT]),
        .exc_ack      (exc_ack),
        .cap_norm     (cap_norm),
        .cap_stop     (cap_stop),
        .trc_req      (trc_req),
        .sr_load      (sr_load),
        .stop_entered (stop_entered)
    );

    trace_seq_frame #(
        .AW       (AW),
        .SW       (SW),
        .STOP_LEN (STOP_LEN)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .cap_norm    (cap_norm),
        .cap_stop    (cap_stop),
        .ins_pc      (ins_pc),
        .ins_next_pc (ins_next_pc),
        .sr_val      (sr_val),
        .stop_imm    (stop_imm),
        .pc_q        (pc_q),
        .sr_q        (sr_q)
    );

    assign trc_pc      = pc_q;
    assign trc_sr      = sr_q;
    assign sr_load_val = sr_q;

endmodule

// File: rtl/trace_seq_chk.sv
module trace_seq_chk #(
    parameter int AW   = 32,
    parameter int SW   = 16,
    parameter int TBIT = 15
) (
    input logic          clk,
    input logic          rst,
    input logic          exc_ack,
    input logic          trc_req,
    input logic [AW-1:0] trc_pc,
    input logic [SW-1:0] trc_sr,
    input logic          sr_load,
    input logic [SW-1:0] sr_load_val,
    input logic          stop_entered
);

    // R4
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trc_req |=> !trc_req);

    // R4
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trc_req && !exc_ack) |=> ($stable(trc_pc) && $stable(trc_sr)));

    // R7
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sr_load |=> !sr_load);

    // R8
    post_trace_chk: assert property (@(posedge clk) disable iff (rst)
        (sr_load && sr_load_val[TBIT]) |=> (trc_req && trc_sr == $past(sr_load_val)));

    // R9
    quiet_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (sr_load && !sr_load_val[TBIT]) |=> (stop_entered && !trc_req));

    // R11
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trc_req, sr_load, stop_entered}));

endmodule

bind trace_seq trace_seq_chk #(.AW(AW), .SW(SW), .TBIT(TBIT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .exc_ack      (exc_ack),
    .trc_req      (trc_req),
    .trc_pc       (trc_pc),
    .trc_sr       (trc_sr),
    .sr_load      (sr_load),
    .sr_load_val  (sr_load_val),
    .stop_entered (stop_entered)
);

// File: tb/tb_trace_seq.sv
`timescale 1ns/1ps
module tb_trace_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_done = 1'b0;
    logic        ins_stop = 1'b0;
    logic [31:0] ins_pc = '0;
    logic [31:0] ins_next_pc = '0;
    logic [15:0] stop_imm = '0;
    logic [15:0] sr_val = '0;
    logic        exc_ack = 1'b0;
    logic        trc_req;
    logic [31:0] trc_pc;
    logic [15:0] trc_sr;
    logic        sr_load;
    logic [15:0] sr_load_val;
    logic        stop_entered;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string tag = "R1";

    // reference model state
    int          m_phase = 0;   // 0 idle, 1 request, 2 holding, 3 loading, 4 stop signal
    bit          m_post = 0;
    logic [31:0] m_pc = '0;
    logic [15:0] m_sr = '0;

    always #2.5 clk = ~clk;

    trace_seq dut (
        .clk(clk), .rst(rst), .ins_done(ins_done), .ins_stop(ins_stop),
        .ins_pc(ins_pc), .ins_next_pc(ins_next_pc), .stop_imm(stop_imm),
        .sr_val(sr_val), .exc_ack(exc_ack), .trc_req(trc_req), .trc_pc(trc_pc),
        .trc_sr(trc_sr), .sr_load(sr_load), .sr_load_val(sr_load_val),
        .stop_entered(stop_entered)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit r, input bit d, input bit st, input logic [31:0] pc,
                              input logic [31:0] nx, input logic [15:0] sr, input logic [15:0] imm,
                              input bit ack);
        if (r) begin
            m_phase = 0; m_post = 0; m_pc = '0; m_sr = '0;
            return;
        end
        case (m_phase)
            0: if (d) begin
                   if (st) begin m_pc = pc + 32'd4; m_sr = imm; m_phase = 3; end
                   else if (sr[15]) begin m_pc = nx; m_sr = sr; m_post = 0; m_phase = 1; end
               end
            1, 2: if (ack) m_phase = m_post ? 4 : 0; else m_phase = 2;
            3: if (m_sr[15]) begin m_post = 1; m_phase = 1; end else m_phase = 4;
            default: begin m_phase = 0; m_post = 0; end
        endcase
    endtask

    task automatic cyc(input bit r, input bit d, input bit st, input logic [31:0] pc,
                       input logic [31:0] nx, input logic [15:0] sr, input logic [15:0] imm,
                       input bit ack);
        rst = r; ins_done = d; ins_stop = st; ins_pc = pc; ins_next_pc = nx;
        sr_val = sr; stop_imm = imm; exc_ack = ack;
        @(posedge clk);
        model_step(r, d, st, pc, nx, sr, imm, ack);
        #1;
        check(tag, "trc_req", 32'(trc_req), 32'(m_phase == 1));
        check(tag, "sr_load", 32'(sr_load), 32'(m_phase == 3));
        check(tag, "stop_entered", 32'(stop_entered), 32'(m_phase == 4));
        check(tag, "trc_pc", trc_pc, m_pc);
        check(tag, "trc_sr", 32'(trc_sr), 32'(m_sr));
        if (m_phase == 3) check(tag, "sr_load_val", 32'(sr_load_val), 32'(m_sr));
    endtask

    task automatic idle(input int n, input bit ack);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 32'h0, 32'h0, 16'h0, 16'h0, ack);
    endtask

    task automatic ins(input logic [31:0] pc, input logic [31:0] nx, input logic [15:0] sr);
        cyc(0, 1, 0, pc, nx, sr, 16'hFFFF, 0);
    endtask

    task automatic stp(input logic [31:0] pc, input logic [15:0] sr, input logic [15:0] imm);
        cyc(0, 1, 1, pc, pc + 32'd2, sr, imm, 0);
    endtask

    initial begin
        // R1 reset state
        tag = "R1";
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 16'h8000, 0, 0);
        idle(1, 0);

        // R2 traced ordinary completion, R4 hold then acknowledge
        tag = "R2";
        ins(32'h100, 32'h102, 16'h8004);
        tag = "R4";
        idle(3, 0);
        idle(1, 1);
        idle(1, 0);

        // R3 trace bit clear
        tag = "R3";
        ins(32'h102, 32'h106, 16'h2704);
        idle(2, 0);

        // R5 completions while a frame is held are ignored
        tag = "R5";
        ins(32'h200, 32'h204, 16'hA000);
        ins(32'h204, 32'h300, 16'h8011);
        ins(32'h300, 32'h310, 16'h8022);
        stp(32'h310, 16'h8000, 16'h2700);
        idle(1, 1);

        // R6 ack in idle has no effect; ack in the request cycle; back-to-back
        tag = "R6";
        idle(2, 1);
        ins(32'h400, 32'h402, 16'h8000);
        cyc(0, 1, 0, 32'h402, 32'h408, 16'h8100, 0, 1);
        ins(32'h408, 32'h40A, 16'h8200);
        idle(1, 1);
        idle(1, 0);

        // R7/R8/R10 instruction before stop, then stop with traced immediate
        tag = "R7";
        ins(32'h4FC, 32'h500, 16'h8000);
        idle(1, 1);
        stp(32'h500, 16'h8000, 16'hA700);
        tag = "R8";
        idle(3, 0);
        tag = "R10";
        idle(1, 1);
        idle(2, 0);

        // R9 stop that clears the trace bit
        tag = "R9";
        stp(32'h600, 16'h8000, 16'h2500);
        idle(3, 0);

        // R8 stop taken with trace off but immediate turning it on; R5 completion during load
        tag = "R8";
        stp(32'h700, 16'h0000, 16'h8300);
        tag = "R5";
        ins(32'h800, 32'h802, 16'h8000);
        ins(32'h802, 32'h804, 16'h8000);
        tag = "R10";
        cyc(0, 1, 0, 32'h900, 32'h902, 16'h8000, 0, 1);
        ins(32'h904, 32'h906, 16'h0000);
        idle(2, 0);

        // R1 reset in the middle of a pending trace
        tag = "R1";
        ins(32'hA00, 32'hA02, 16'h8000);
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        idle(2, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule